// File: doc/BRIEF.md
# Three-Level Nesting Interrupt Arbiter

This block sits between a set of ten vector-level interrupt request lines and a CPU. Every cycle it looks at the vectors that are both pending and enabled, gives each one a priority level from its select bits, and picks a single winner. The winner is offered to the CPU as a vector address on a valid/ready channel. The CPU takes it by asserting ready. When the CPU finishes a handler it pulses the return strobe.

There are three levels. From the top they are highest, high and low. Only the first two vectors can be raised to highest. The block keeps a short stack of the levels whose handlers are running, so it always knows the current service level. A request is offered only if its level is strictly above that service level. With no handler running, any level qualifies. Vector addresses come from a fixed table: a base of 03h and a step of 8 per vector index. This gives 03h, 0Bh, 13h and so on, up to 4Bh.

Back-pressure rules for the vector channel are as follows. Once `vec_valid` rises, it stays high, and `vec_addr` and `vec_lvl` stay frozen, until the cycle in which `vec_ready` is sampled high. Changes on the request inputs during that time do not alter the offer. After the handshake `vec_valid` is low for at least one cycle. The next choice is made against the service level that includes the level just accepted.

Top module: `irq_arbiter`

## Requirements
- R1: After reset `vec_valid` is low, nothing is in service, and with no request pending no offer is made.
- R2: Level codes on `vec_lvl` are 1 = low, 2 = high and 3 = highest. For vector i, `req_hi[i]`=1 selects high and 0 selects low. For vectors 0 and 1 only, `req_top[i]`=1 selects highest and overrides `req_hi[i]`.
- R3: A vector competes only when both its `req_pend` bit and its `req_en` bit are 1.
- R4: Among competing vectors the highest level wins. Within one level the lowest vector index wins.
- R5: `vec_addr` equals 03h + 8 × (winning index), so index 0 gives 03h and index 9 gives 4Bh.
- R6: A competing request is offered only if its level is strictly above the current service level. An equal or lower level waits. With nothing in service, a low request qualifies.
- R7: While `vec_valid` is high and `vec_ready` is low, `vec_valid` stays high and `vec_addr` and `vec_lvl` do not change, whatever the request inputs do.
- R8: In the cycle after a handshake (`vec_valid` and `vec_ready` both high), `vec_valid` is low. The next offer is chosen against the updated service level.
- R9: A handshake pushes the accepted level, which becomes the service level. A `reti` pulse pops the top entry and restores the level below it. A `reti` with nothing in service is ignored.
- R10: A `reti` in the same cycle as a handshake pops first and then pushes. The accepted level replaces the top entry, and the depth is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pend | input | 10 | Pending flag per vector |
| req_en | input | 10 | Enable per vector |
| req_hi | input | 10 | Level select per vector: 1 = high, 0 = low |
| req_top | input | 2 | Highest-level select for vectors 0 and 1 |
| vec_valid | output | 1 | Vector offer valid |
| vec_ready | input | 1 | CPU acknowledge (ready) |
| vec_addr | output | 16 | Offered vector address |
| vec_lvl | output | 2 | Level of the offered vector |
| reti | input | 1 | Return-from-interrupt strobe |

## Verification
The delicate overlap is a return strobe arriving in the same cycle as the acknowledge of a new vector. In that cycle the service stack must pop and push at once.

The bench provokes it as follows:
- A low vector is in service.
- A high offer is acknowledged with `reti` raised on the same clock edge.

The bench then judges the stack state from outside:
- A further high request must stay blocked, which proves the high entry landed.
- After one more return a low request must be delivered, which proves the low entry was popped rather than kept underneath.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Service / request level codes; order matters: comparisons use it.
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } lvl_e;

  // One stack slot per real level is always enough: nesting is strictly rising.
  localparam int unsigned NUM_REAL_LVLS = 3;

endpackage

// File: rtl/irq_lvl_map.sv
module irq_lvl_map
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_VEC = 10,
  parameter int unsigned NUM_TOP = 2
) (
  input  logic [NUM_VEC-1:0]      pend,
  input  logic [NUM_VEC-1:0]      enable,
  input  logic [NUM_VEC-1:0]      sel_hi,
  input  logic [NUM_TOP-1:0]      sel_top,
  output logic [NUM_VEC-1:0][1:0] vec_lvl
);

  logic [NUM_VEC-1:0] live;
  assign live = pend & enable;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    if (i < NUM_TOP) begin : g_top_capable
      assign vec_lvl[i] = !live[i]   ? LVL_NONE :
                          sel_top[i] ? LVL_TOP  :
                          sel_hi[i]  ? LVL_HIGH : LVL_LOW;
    end else begin : g_two_level
      assign vec_lvl[i] = !live[i]  ? LVL_NONE :
                          sel_hi[i] ? LVL_HIGH : LVL_LOW;
    end
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_VEC = 10,
  localparam int unsigned IDX_W = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0][1:0] vec_lvl,
  output logic                    found,
  output logic [IDX_W-1:0]        win_idx,
  output logic [1:0]              win_lvl
);

  // Scan from the top index down; ">=" lets a lower index take over a tie.
  always_comb begin
    win_lvl = LVL_NONE;
    win_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (vec_lvl[i] != LVL_NONE && vec_lvl[i] >= win_lvl) begin
        win_lvl = vec_lvl[i];
        win_idx = IDX_W'(i);
      end
    end
    found = (win_lvl != LVL_NONE);
  end

endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
  import irq_arb_pkg::*;
#(
  parameter int unsigned DEPTH = NUM_REAL_LVLS,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [1:0] push_lvl,
  input  logic       pop,
  output logic [1:0] top_lvl
);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       slot [DEPTH];
  logic [CNT_W-1:0] top_ix;
  logic             do_pop;

  assign top_ix  = cnt - 1'b1;
  assign do_pop  = pop && (cnt != '0);
  assign top_lvl = (cnt == '0) ? LVL_NONE : slot[top_ix];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int j = 0; j < DEPTH; j++) slot[j] <= LVL_NONE;
    end else if (push && do_pop) begin
      slot[top_ix] <= push_lvl;            // pop then push: replace top
    end else if (push && cnt != CNT_W'(DEPTH)) begin
      slot[cnt] <= push_lvl;
      cnt       <= cnt + 1'b1;
    end else if (do_pop) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 10,
  parameter int unsigned NUM_TOP  = 2,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] req_pend,
  input  logic [NUM_VEC-1:0] req_en,
  input  logic [NUM_VEC-1:0] req_hi,
  input  logic [NUM_TOP-1:0] req_top,
  output logic               vec_valid,
  input  logic               vec_ready,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [1:0]         vec_lvl,
  input  logic               reti
);

  localparam int unsigned IDX_W     = $clog2(NUM_VEC);
  localparam int unsigned SVC_DEPTH = NUM_REAL_LVLS;

  logic [NUM_VEC-1:0][1:0] lvl_vec;
  logic                    found;
  logic [IDX_W-1:0]        win_idx;
  logic [1:0]              win_lvl;
  logic [1:0]              cur_lvl;
  logic [IDX_W-1:0]        off_idx;
  logic                    handshake;

  irq_lvl_map #(.NUM_VEC(NUM_VEC), .NUM_TOP(NUM_TOP)) u_map (
    .pend    (req_pend),
    .enable  (req_en),
    .sel_hi  (req_hi),
    .sel_top (req_top),
    .vec_lvl (lvl_vec)
  );

  irq_pick #(.NUM_VEC(NUM_VEC)) u_pick (
    .vec_lvl (lvl_vec),
    .found   (found),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  assign handshake = vec_valid && vec_ready;

  irq_svc_stack #(.DEPTH(SVC_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (handshake),
    .push_lvl (vec_lvl),
    .pop      (reti),
    .top_lvl  (cur_lvl)
  );

  // Offer register: frozen while waiting, dropped for one cycle after a handshake.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      off_idx   <= '0;
      vec_lvl   <= LVL_NONE;
    end else if (vec_valid) begin
      if (vec_ready) vec_valid <= 1'b0;
    end else if (found && win_lvl > cur_lvl) begin
      vec_valid <= 1'b1;
      off_idx   <= win_idx;
      vec_lvl   <= win_lvl;
    end
  end

  assign vec_addr = ADDR_W'(VEC_BASE) + ADDR_W'(off_idx) * ADDR_W'(VEC_STEP);

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int unsigned NUM_TOP  = 2,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [1:0]        vec_lvl,
  input logic [1:0]        cur_lvl
);

  localparam logic [ADDR_W-1:0] TOP_LIMIT = ADDR_W'(VEC_BASE + NUM_TOP * VEC_STEP);
  localparam logic [ADDR_W-1:0] BASE_A    = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] STEP_A    = ADDR_W'(VEC_STEP);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_addr) && $stable(vec_lvl));

  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready |=> !vec_valid);

  p_preempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> vec_lvl > $past(cur_lvl));

  p_top_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_lvl == 2'd3 |-> vec_addr < TOP_LIMIT);

  p_addr_grid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec_addr >= BASE_A && ((vec_addr - BASE_A) % STEP_A) == '0);

  // R9 and R10: after any handshake the accepted level is on top of the stack.
  p_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready |=> cur_lvl == $past(vec_lvl));

endmodule

bind irq_arbiter irq_arb_chk #(
  .NUM_TOP  (NUM_TOP),
  .ADDR_W   (ADDR_W),
  .VEC_BASE (VEC_BASE),
  .VEC_STEP (VEC_STEP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vec_valid (vec_valid),
  .vec_ready (vec_ready),
  .vec_addr  (vec_addr),
  .vec_lvl   (vec_lvl),
  .cur_lvl   (cur_lvl)
);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;

  localparam int N = 10;
  localparam int L_LOW = 1, L_HIGH = 2, L_TOP = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_pend = '0, req_en = '0, req_hi = '0;
  logic [1:0]   req_top = '0;
  logic         vec_ready = 1'b0, reti = 1'b0;
  logic         vec_valid;
  logic [15:0]  vec_addr;
  logic [1:0]   vec_lvl;

  always #4 clk = ~clk;   // 125 MHz

  irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .req_en(req_en),
    .req_hi(req_hi), .req_top(req_top), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_addr(vec_addr), .vec_lvl(vec_lvl), .reti(reti)
  );

  int    n_chk = 0, n_fail = 0;
  bit    ended = 0;
  int    q_addr[$];
  int    q_lvl[$];
  string q_tag[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Driver side of the scoreboard: expected deliveries.
  task automatic expect_vec(int idx, int lvl, string tag);
    q_addr.push_back(3 + 8 * idx);
    q_lvl.push_back(lvl);
    q_tag.push_back(tag);
  endtask

  // Monitor: every handshake is compared with the queue head.
  always @(negedge clk) begin
    if (rst_n && vec_valid && vec_ready) begin
      if (q_addr.size() == 0) begin
        check(0, "R6", "unexpected delivery addr", int'(vec_addr), -1);
      end else begin
        automatic int    ea = q_addr.pop_front();
        automatic int    el = q_lvl.pop_front();
        automatic string et = q_tag.pop_front();
        check(int'(vec_addr) == ea, et, "vector address", int'(vec_addr), ea);
        check(int'(vec_lvl) == el, et, "vector level", int'(vec_lvl), el);
      end
    end
  end

  task automatic deliver(bit with_reti, string req);
    automatic bit seen = 0;
    for (int k = 0; k < 50; k++) begin
      if (vec_valid) begin seen = 1; break; end
      step();
    end
    check(seen, req, "offer appeared", int'(seen), 1);
    if (seen) begin
      vec_ready = 1'b1; reti = with_reti;
      step();
      vec_ready = 1'b0; reti = 1'b0;
    end
  endtask

  task automatic quiet(int n, string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(!vec_valid, req, "no offer while blocked", int'(vec_valid), 0);
    end
    step();
  endtask

  task automatic reti_pulse();
    reti = 1'b1; step(); reti = 1'b0; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    check(!vec_valid, "R1", "valid after reset", int'(vec_valid), 0);
    quiet(3, "R1");

    // R4/R5: three low vectors tie, lowest index wins
    req_en = '1; req_pend[3] = 1; req_pend[5] = 1; req_pend[7] = 1;
    expect_vec(3, L_LOW, "R4"); deliver(0, "R4"); req_pend[3] = 0;
    quiet(4, "R6");                                   // equal level blocked
    reti_pulse();
    expect_vec(5, L_LOW, "R5"); deliver(0, "R5"); req_pend[5] = 0;
    reti_pulse();
    expect_vec(7, L_LOW, "R5"); deliver(0, "R5"); req_pend[7] = 0;
    reti_pulse();

    // R3: disabled highest request does not compete; R2 high level
    req_en[0] = 0; req_top[0] = 1; req_pend[0] = 1;
    req_hi[9] = 1; req_pend[9] = 1;
    expect_vec(9, L_HIGH, "R3"); deliver(0, "R3"); req_pend[9] = 0;
    quiet(3, "R3");
    req_en[0] = 1;
    expect_vec(0, L_TOP, "R2"); deliver(0, "R6"); req_pend[0] = 0;
    req_top[1] = 1; req_pend[1] = 1;
    quiet(3, "R6");                                   // highest vs highest
    reti_pulse();
    expect_vec(1, L_TOP, "R2"); deliver(0, "R2"); req_pend[1] = 0; req_top = '0;
    reti_pulse(); reti_pulse();
    reti_pulse(); reti_pulse();                       // R9: returns on empty stack

    // R9: push, pop restores the level below
    req_hi = '0; req_pend[2] = 1;
    expect_vec(2, L_LOW, "R9"); deliver(0, "R9"); req_pend[2] = 0;
    req_hi[4] = 1; req_pend[4] = 1;
    expect_vec(4, L_HIGH, "R2"); deliver(0, "R9"); req_pend[4] = 0;
    reti_pulse();
    req_pend[6] = 1;
    quiet(3, "R9");                                   // restored low blocks low
    req_hi[8] = 1; req_pend[8] = 1;
    expect_vec(8, L_HIGH, "R9"); deliver(0, "R9"); req_pend[8] = 0;
    reti_pulse(); reti_pulse();
    expect_vec(6, L_LOW, "R9"); deliver(0, "R9"); req_pend[6] = 0;
    reti_pulse();

    // R7: offer held under back-pressure; R8: gap then re-arbitration
    req_hi = '0; req_pend[3] = 1;
    for (int k = 0; k < 50 && !vec_valid; k++) step();
    req_top[0] = 1; req_pend[0] = 1; req_pend[3] = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(vec_valid == 1'b1, "R7", "valid held", int'(vec_valid), 1);
      check(int'(vec_addr) == 27, "R7", "addr held", int'(vec_addr), 27);
      check(int'(vec_lvl) == L_LOW, "R7", "level held", int'(vec_lvl), L_LOW);
    end
    step();
    expect_vec(3, L_LOW, "R7"); deliver(0, "R7");
    @(negedge clk);
    check(!vec_valid, "R8", "gap after handshake", int'(vec_valid), 0);
    step();
    expect_vec(0, L_TOP, "R8"); deliver(0, "R8"); req_pend[0] = 0; req_top = '0;
    reti_pulse(); reti_pulse();

    // R10: return and acknowledge in the same cycle
    req_pend[5] = 1;
    expect_vec(5, L_LOW, "R10"); deliver(0, "R10"); req_pend[5] = 0;
    req_hi[6] = 1; req_pend[6] = 1;
    expect_vec(6, L_HIGH, "R10"); deliver(1, "R10"); req_pend[6] = 0;
    req_hi[9] = 1; req_pend[9] = 1;
    quiet(3, "R10");                                  // high now on top
    req_pend[9] = 0;
    reti_pulse();
    req_hi[7] = 0; req_pend[7] = 1;
    expect_vec(7, L_LOW, "R10"); deliver(0, "R10"); req_pend[7] = 0;

    repeat (4) step();
    check(q_addr.size() == 0, "R4", "undelivered expected items", q_addr.size(), 0);
    finish_run();
  end

endmodule